// File: doc/BRIEF.md
# Frequency Multiplier Configuration and Enable Sequencer

This block is the digital control around an on-chip frequency multiplier loop. It holds the multiplication factor and the choice of reference clock, and it applies a fixed bring-up order: pick a reference, configure, wait for the reference to report stable, then turn the loop on. It watches a lock flag from the analog loop and raises a ready output only when the multiplied clock can be used. The loop output frequency is the reference frequency times the stored factor.

Software drives three independent write strobes, one each for the factor, the reference select and the enable request. While the loop is enabled the configuration is frozen. The block also drives one inhibit line per reference oscillator. The oscillator controls use these lines to refuse a disable request for the reference in use. A request to enable that arrives before the reference is stable is held, and the loop is started as soon as stability appears.

Top module: `pll_cfg_ctrl`

## Requirements
- R1: After reset the stored factor is 1, the reference select is 0, and loop enable, ready and every inhibit line are low.
- R2: A factor write with a value from 1 to 31, made while loop enable is low, appears on the factor output after the next clock edge.
- R3: A factor write of 0 is stored as 1, so the stored factor is never 0.
- R4: A reference select write made while loop enable is low appears on the select output after the next clock edge. The codes are 0 for the 2 MHz internal oscillator, 1 for the 32 MHz internal oscillator divided by 4, 2 for the 0.4 to 16 MHz crystal oscillator and 3 for the external clock.
- R5: Factor and reference select writes made while loop enable is high leave both stored values unchanged.
- R6: An enable request keeps loop enable low while the selected reference is not stable. The request is kept, and loop enable rises on the clock edge that first sees the selected stable flag high.
- R7: Ready rises one edge after lock is seen high with the loop enabled and the reference stable. Ready is never high while loop enable is low.
- R8: If lock drops while ready is high, ready falls after the next edge and loop enable stays high.
- R9: If the selected reference loses stability while the loop is enabled, loop enable and ready fall after the next edge. The loop restarts by itself when stability returns.
- R10: Writing enable as 0 drives loop enable, ready and all inhibit lines low within two clock edges.
- R11: While an enable request is active, exactly the inhibit bit whose index equals the selected reference code is high. This holds from the edge after the request is stored until it is withdrawn.
- R12: Stable flags of references that are not selected have no effect on the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fac_wr | input | 1 | Factor write strobe |
| fac_wdata | input | 5 | Factor write value |
| src_wr | input | 1 | Reference select write strobe |
| src_wdata | input | 2 | Reference select write value |
| en_wr | input | 1 | Enable request write strobe |
| en_wdata | input | 1 | Enable request value |
| src_stable | input | 4 | Stable flag per reference, indexed by select code |
| loop_lock | input | 1 | Lock flag from the analog loop |
| cfg_fac | output | 5 | Stored multiplication factor |
| cfg_src | output | 2 | Stored reference select |
| loop_en | output | 1 | Enable to the analog loop |
| pll_ready | output | 1 | Multiplied clock usable |
| src_dis_inhibit | output | 4 | Per-reference disable inhibit |

## Verification
A wrong sequencer state shows up at the ports one edge later. It appears as loop enable rising against a non-stable reference, ready staying high after lock is lost, or loop enable staying high after the request is withdrawn. A faulty write-protect shows up one edge after a write as a changed factor or select while the loop runs. The sweeps run every factor value and every reference code, and they flip the stable flags of the other references to expose a wrong index. A wrong inhibit index or a stale inhibit after disable shows on the same cycle the sequence is checked.

// File: rtl/pll_cfg_pkg.sv
package pll_cfg_pkg;

    localparam int unsigned FAC_W = 5;
    localparam int unsigned N_SRC = 4;
    localparam int unsigned SRC_W = $clog2(N_SRC);

    typedef enum logic [1:0] {
        ST_OFF         = 2'd0,
        ST_WAIT_STABLE = 2'd1,
        ST_WAIT_LOCK   = 2'd2,
        ST_READY       = 2'd3
    } seq_state_e;

endpackage

// File: rtl/pll_cfg_regs.sv
module pll_cfg_regs #(
    parameter int unsigned FAC_W = 5,
    parameter int unsigned SRC_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fac_wr,
    input  logic [FAC_W-1:0] fac_wdata,
    input  logic             src_wr,
    input  logic [SRC_W-1:0] src_wdata,
    input  logic             en_wr,
    input  logic             en_wdata,
    input  logic             frozen_i,
    output logic [FAC_W-1:0] fac_o,
    output logic [SRC_W-1:0] src_o,
    output logic             en_req_o
);

    localparam logic [FAC_W-1:0] FAC_ONE = FAC_W'(1);

    typedef struct packed {
        logic [FAC_W-1:0] fac;
        logic [SRC_W-1:0] src;
        logic             en_req;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (!frozen_i) begin
            if (fac_wr) begin
                r_d.fac = (fac_wdata == '0) ? FAC_ONE : fac_wdata;
            end
            if (src_wr) begin
                r_d.src = src_wdata;
            end
        end
        if (en_wr) begin
            r_d.en_req = en_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.fac    <= FAC_ONE;
            r_q.src    <= '0;
            r_q.en_req <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign fac_o    = r_q.fac;
    assign src_o    = r_q.src;
    assign en_req_o = r_q.en_req;

    p_cfg_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
        frozen_i |=> ($stable(fac_o) && $stable(src_o)));

    p_fac_nonzero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        fac_o != '0);

    p_fac_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (fac_wr && !frozen_i && fac_wdata != '0) |=> (fac_o == $past(fac_wdata)));

endmodule

// File: rtl/pll_cfg_seq.sv
module pll_cfg_seq
    import pll_cfg_pkg::*;
#(
    parameter int unsigned N_SRC = 4,
    parameter int unsigned SRC_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_req_i,
    input  logic [N_SRC-1:0] src_stable_i,
    input  logic [SRC_W-1:0] src_sel_i,
    input  logic             lock_i,
    output logic             loop_en_o,
    output logic             ready_o,
    output logic             active_o
);

    typedef struct packed {
        seq_state_e st;
    } seq_t;

    seq_t s_d, s_q;
    logic stable_sel;

    assign stable_sel = src_stable_i[src_sel_i];

    always_comb begin
        s_d = s_q;
        if (!en_req_i) begin
            s_d.st = ST_OFF;
        end else begin
            unique case (s_q.st)
                ST_OFF:         s_d.st = ST_WAIT_STABLE;
                ST_WAIT_STABLE: if (stable_sel) s_d.st = ST_WAIT_LOCK;
                ST_WAIT_LOCK: begin
                    if (!stable_sel)  s_d.st = ST_WAIT_STABLE;
                    else if (lock_i)  s_d.st = ST_READY;
                end
                ST_READY: begin
                    if (!stable_sel)  s_d.st = ST_WAIT_STABLE;
                    else if (!lock_i) s_d.st = ST_WAIT_LOCK;
                end
                default:          s_d.st = ST_OFF;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.st <= ST_OFF;
        end else begin
            s_q <= s_d;
        end
    end

    assign loop_en_o = (s_q.st == ST_WAIT_LOCK) || (s_q.st == ST_READY);
    assign ready_o   = (s_q.st == ST_READY);
    assign active_o  = (s_q.st != ST_OFF);

    p_enable_after_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(loop_en_o) |-> $past(stable_sel && en_req_i));

    p_ready_after_lock_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready_o) |-> $past(lock_i && stable_sel && loop_en_o));

    p_lock_loss_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_o && !lock_i && stable_sel && en_req_i) |=> (!ready_o && loop_en_o));

    p_stab_loss_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (loop_en_o && !stable_sel) |=> (!loop_en_o && !ready_o));

    p_release_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !en_req_i |=> (!active_o && !loop_en_o));

endmodule

// File: rtl/pll_cfg_inhibit.sv
module pll_cfg_inhibit #(
    parameter int unsigned N_SRC = 4,
    parameter int unsigned SRC_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active_i,
    input  logic [SRC_W-1:0] src_sel_i,
    output logic [N_SRC-1:0] inhibit_o
);

    for (genvar g = 0; g < N_SRC; g++) begin : g_inh
        assign inhibit_o[g] = active_i && (src_sel_i == SRC_W'(g));
    end

    p_inhibit_onehot_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(inhibit_o));

    p_inhibit_active_r11: assert property (@(posedge clk) disable iff (!rst_n)
        active_i |-> ($countones(inhibit_o) == 1));

endmodule

// File: rtl/pll_cfg_ctrl.sv
module pll_cfg_ctrl
    import pll_cfg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fac_wr,
    input  logic [FAC_W-1:0] fac_wdata,
    input  logic             src_wr,
    input  logic [SRC_W-1:0] src_wdata,
    input  logic             en_wr,
    input  logic             en_wdata,
    input  logic [N_SRC-1:0] src_stable,
    input  logic             loop_lock,
    output logic [FAC_W-1:0] cfg_fac,
    output logic [SRC_W-1:0] cfg_src,
    output logic             loop_en,
    output logic             pll_ready,
    output logic [N_SRC-1:0] src_dis_inhibit
);

    logic en_req;
    logic seq_active;

    pll_cfg_regs #(
        .FAC_W (FAC_W),
        .SRC_W (SRC_W)
    ) i_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .fac_wr   (fac_wr),
        .fac_wdata(fac_wdata),
        .src_wr   (src_wr),
        .src_wdata(src_wdata),
        .en_wr    (en_wr),
        .en_wdata (en_wdata),
        .frozen_i (loop_en),
        .fac_o    (cfg_fac),
        .src_o    (cfg_src),
        .en_req_o (en_req)
    );

    pll_cfg_seq #(
        .N_SRC (N_SRC),
        .SRC_W (SRC_W)
    ) i_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .en_req_i    (en_req),
        .src_stable_i(src_stable),
        .src_sel_i   (cfg_src),
        .lock_i      (loop_lock),
        .loop_en_o   (loop_en),
        .ready_o     (pll_ready),
        .active_o    (seq_active)
    );

    pll_cfg_inhibit #(
        .N_SRC (N_SRC),
        .SRC_W (SRC_W)
    ) i_inh (
        .clk      (clk),
        .rst_n    (rst_n),
        .active_i (seq_active),
        .src_sel_i(cfg_src),
        .inhibit_o(src_dis_inhibit)
    );

    p_ready_implies_en_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pll_ready |-> loop_en);

endmodule

// File: tb/test_pll_cfg_ctrl.sv
module test_pll_cfg_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fac_wr = 1'b0;
    logic [4:0] fac_wdata = '0;
    logic       src_wr = 1'b0;
    logic [1:0] src_wdata = '0;
    logic       en_wr = 1'b0;
    logic       en_wdata = 1'b0;
    logic [3:0] src_stable = '0;
    logic       loop_lock = 1'b0;
    logic [4:0] cfg_fac;
    logic [1:0] cfg_src;
    logic       loop_en;
    logic       pll_ready;
    logic [3:0] src_dis_inhibit;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    pll_cfg_ctrl i_pll_cfg_ctrl (
        .clk(clk), .rst_n(rst_n),
        .fac_wr(fac_wr), .fac_wdata(fac_wdata),
        .src_wr(src_wr), .src_wdata(src_wdata),
        .en_wr(en_wr), .en_wdata(en_wdata),
        .src_stable(src_stable), .loop_lock(loop_lock),
        .cfg_fac(cfg_fac), .cfg_src(cfg_src),
        .loop_en(loop_en), .pll_ready(pll_ready),
        .src_dis_inhibit(src_dis_inhibit)
    );

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr_fac(logic [4:0] v);
        fac_wr = 1'b1; fac_wdata = v;
        @(negedge clk);
        fac_wr = 1'b0;
    endtask

    task automatic wr_src(logic [1:0] v);
        src_wr = 1'b1; src_wdata = v;
        @(negedge clk);
        src_wr = 1'b0;
    endtask

    task automatic wr_en(logic v);
        en_wr = 1'b1; en_wdata = v;
        @(negedge clk);
        en_wr = 1'b0;
    endtask

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        // R1 reset state
        chk("R1 fac", cfg_fac, 1);
        chk("R1 src", cfg_src, 0);
        chk("R1 loop_en", loop_en, 0);
        chk("R1 ready", pll_ready, 0);
        chk("R1 inhibit", src_dis_inhibit, 0);

        // R2/R3 factor sweep with loop off
        for (int v = 0; v < 32; v++) begin
            wr_fac(5'(v));
            chk((v == 0) ? "R3 zero factor" : "R2 factor", cfg_fac, (v == 0) ? 1 : v);
        end

        for (int s = 0; s < 4; s++) begin
            src_stable = '0;
            loop_lock  = 1'b0;
            wr_src(2'(s));
            chk("R4 select", cfg_src, s);
            wr_fac(5'(s + 3));
            // R12 other references stable, selected not
            src_stable = 4'(~(4'b1 << s));
            wr_en(1'b1);
            step(3);
            chk("R6/R12 held off", loop_en, 0);
            chk("R11 inhibit pending", src_dis_inhibit, 1 << s);
            chk("R7 not ready", pll_ready, 0);
            src_stable = 4'hf;
            step(1);
            chk("R6 enable on stable", loop_en, 1);
            wr_fac(5'd20);
            chk("R5 factor frozen", cfg_fac, s + 3);
            wr_src(2'((s + 1) % 4));
            chk("R5 select frozen", cfg_src, s);
            loop_lock = 1'b1;
            step(1);
            chk("R7 ready", pll_ready, 1);
            loop_lock = 1'b0;
            step(1);
            chk("R8 ready drop", pll_ready, 0);
            chk("R8 loop kept", loop_en, 1);
            loop_lock = 1'b1;
            step(1);
            chk("R7 ready again", pll_ready, 1);
            src_stable = 4'hf & ~(4'b1 << s);
            step(1);
            chk("R9 loop off", loop_en, 0);
            chk("R9 ready off", pll_ready, 0);
            chk("R11 inhibit kept", src_dis_inhibit, 1 << s);
            src_stable = 4'hf;
            step(1);
            chk("R9 restart", loop_en, 1);
            step(1);
            chk("R9 ready restart", pll_ready, 1);
            wr_en(1'b0);
            step(1);
            chk("R10 loop off", loop_en, 0);
            chk("R10 ready off", pll_ready, 0);
            chk("R10 inhibit off", src_dis_inhibit, 0);
            wr_fac(5'd31);
            chk("R2 writable after disable", cfg_fac, 31);
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule